// File: doc/BRIEF.md
# Two-Level Interval Timestamp Readout

This block is the digital back end of one timing channel built around two ring oscillators. The oscillators themselves are not modelled. The block sees four things from the analog front end: a sampled phase pattern of the coarse ring, a tick for each lap of that ring, a resolved interpolation count from the slower second ring, and the channel's START and STOP events. From these it forms one timestamp in fine units. Each coarse step is 50ps, made of four ring stages per lap. The interpolation divides each coarse step into eight fine steps of 6.25ps. The timestamp value is `((lap * 4 + stage) * 8 + fine)`.

Each channel measures two intervals, time-of-arrival and time-over-threshold, and each interval gets its own lane (lane 0 and lane 1). Every lane runs through five states in order: idle, running, coarse latched, waiting for the interpolation, and output. A finished result leaves the lane on a valid/ready stream. `out_valid` stays high and the code and flags stay stable until `out_ready` is seen high at a clock edge. The lane accepts no new START until the result has been taken. The lap counter width is a parameter. One more bit doubles the range, and the output code width follows from it.

Top module: `tdc_vernier_readout`

## Requirements
- R1: After reset every lane has `out_valid` low and a drop count of zero.
- R2: In idle, a START pulse arms the lane and clears its lap count. Each lap tick then adds one to the count. A STOP in the running state latches `{lap, stage}`. The interpolation-done strobe is accepted from the second cycle after STOP. `out_valid` rises in the cycle after that strobe, with code `(lap*4+stage)*8+fine`.
- R3: The phase input of each lane is 3 bits wide. The stage index equals the number of consecutive ones counted upward from bit 0. A one above the first zero is a bubble and is ignored, so 3'b101 decodes to stage 1 and 3'b111 decodes to stage 3.
- R4: The fine count is 4 bits wide. A count with bit 3 set (8 to 15) sets `out_err`, and the code becomes `(lap*4+stage)*8`.
- R5: If no done strobe arrives within FINE_TMO (16) cycles of waiting, the lane emits a result with `out_err` set and code `(lap*4+stage)*8`.
- R6: A lap tick while the lap count is at its maximum (7) ends the measurement. The lane emits a result with `out_oor` set, `out_err` clear and code 0, then returns to idle.
- R7: While `out_valid` is high and `out_ready` is low, valid, code and flags hold unchanged. The lane returns to idle at the edge where `out_ready` is high.
- R8: A STOP received in idle is ignored. No result appears, and the next measurement is unaffected.
- R9: A START received in any state other than idle adds one to the lane's drop count, which saturates at its maximum. It does not alter the result in flight.
- R10: Lane 0 and lane 1 operate independently. Activity on one lane changes no output of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 2 | START pulse per lane |
| stop_i | input | 2 | STOP pulse per lane |
| lap_tick_i | input | 2 | One pulse per coarse ring lap, per lane |
| phase_i | input | 6 | Sampled ring phase, 3 bits per lane |
| fine_done_i | input | 2 | Interpolation resolved strobe per lane |
| fine_cnt_i | input | 8 | Interpolation count, 4 bits per lane |
| out_ready_i | input | 2 | Consumer ready per lane |
| out_valid_o | output | 2 | Result valid per lane |
| out_code_o | output | 16 | Timestamp in fine units, 8 bits per lane |
| out_err_o | output | 2 | Interpolation failed (qualified by valid) |
| out_oor_o | output | 2 | Lap counter overflowed (qualified by valid) |
| drop_cnt_o | output | 16 | Saturating dropped-START count, 8 bits per lane |

## Verification
The lap-overflow and interpolation-timeout exits are the two paths that are hardest to reach. Normal stimulus never lets them happen, because a real STOP or done strobe arrives first. The bench reaches them with directed sequences: one issues a full eight lap ticks with STOP withheld, and the other opens the interpolation window and never pulses done. It counts cycles so that valid is shown low one cycle before the deadline and high at the deadline. Bubble patterns in the phase input and out-of-range fine counts come out of the seeded random sweep over all 3-bit phase values and selected fine values.

// File: rtl/tdc_readout_pkg.sv
package tdc_readout_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_LATCH = 3'd2,
    ST_FWAIT = 3'd3,
    ST_OUT   = 3'd4
  } lane_state_e;
endpackage

// File: rtl/tdc_phase_decode.sv
module tdc_phase_decode #(
  parameter int STAGES = 4,
  localparam int PW = STAGES - 1,
  localparam int SW = $clog2(STAGES)
) (
  input  logic [PW-1:0] phase,
  output logic [SW-1:0] stage
);
  logic [STAGES-1:0] edge_hot;

  assign edge_hot[0]        = ~phase[0];
  assign edge_hot[STAGES-1] = phase[PW-1];
  generate
    for (genvar k = 1; k < STAGES - 1; k++) begin : g_edge
      assign edge_hot[k] = phase[k-1] & ~phase[k];
    end
  endgenerate

  // lowest transition wins; higher ones are bubbles
  always_comb begin
    stage = SW'(STAGES - 1);
    for (int k = STAGES - 1; k >= 0; k--) begin
      if (edge_hot[k]) stage = SW'(k);
    end
  end
endmodule

// File: rtl/tdc_lane.sv
module tdc_lane
  import tdc_readout_pkg::*;
#(
  parameter int STAGES   = 4,
  parameter int LAPW     = 3,
  parameter int FINEW    = 3,
  parameter int FINE_TMO = 16,
  parameter int DROPW    = 8,
  localparam int PW    = STAGES - 1,
  localparam int SW    = $clog2(STAGES),
  localparam int CODEW = LAPW + SW + FINEW,
  localparam int TMOW  = $clog2(FINE_TMO + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             lap_tick,
  input  logic [PW-1:0]    phase,
  input  logic             fine_done,
  input  logic [FINEW:0]   fine_cnt,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [CODEW-1:0] out_code,
  output logic             out_err,
  output logic             out_oor,
  output logic [DROPW-1:0] drop_cnt
);
  lane_state_e            state;
  logic [LAPW-1:0]        lap;
  logic [LAPW+SW-1:0]     coarse;
  logic [TMOW-1:0]        tmo;
  logic [CODEW-1:0]       code_q;
  logic                   err_q, oor_q;
  logic [SW-1:0]          stage;

  tdc_phase_decode #(.STAGES(STAGES)) u_dec (.phase(phase), .stage(stage));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      lap      <= '0;
      coarse   <= '0;
      tmo      <= '0;
      code_q   <= '0;
      err_q    <= 1'b0;
      oor_q    <= 1'b0;
      drop_cnt <= '0;
    end else begin
      if (start && state != ST_IDLE && drop_cnt != '1)
        drop_cnt <= drop_cnt + 1'b1;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          lap   <= '0;
          err_q <= 1'b0;
          oor_q <= 1'b0;
        end
        ST_RUN: begin
          if (stop) begin
            coarse <= {lap, stage};
            state  <= ST_LATCH;
          end else if (lap_tick) begin
            if (lap == '1) begin
              oor_q  <= 1'b1;
              code_q <= '0;
              state  <= ST_OUT;
            end else begin
              lap <= lap + 1'b1;
            end
          end
        end
        ST_LATCH: begin
          tmo   <= '0;
          state <= ST_FWAIT;
        end
        ST_FWAIT: begin
          if (fine_done) begin
            err_q  <= fine_cnt[FINEW];
            code_q <= fine_cnt[FINEW] ? {coarse, {FINEW{1'b0}}}
                                      : {coarse, fine_cnt[FINEW-1:0]};
            state  <= ST_OUT;
          end else if (tmo == TMOW'(FINE_TMO - 1)) begin
            err_q  <= 1'b1;
            code_q <= {coarse, {FINEW{1'b0}}};
            state  <= ST_OUT;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = (state == ST_OUT);
  assign out_code  = code_q;
  assign out_err   = out_valid & err_q;
  assign out_oor   = out_valid & oor_q;
endmodule

// File: rtl/tdc_vernier_readout.sv
module tdc_vernier_readout #(
  parameter int NLANE    = 2,
  parameter int STAGES   = 4,
  parameter int LAPW     = 3,
  parameter int FINEW    = 3,
  parameter int FINE_TMO = 16,
  parameter int DROPW    = 8,
  localparam int PW    = STAGES - 1,
  localparam int SW    = $clog2(STAGES),
  localparam int CODEW = LAPW + SW + FINEW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLANE-1:0]         start_i,
  input  logic [NLANE-1:0]         stop_i,
  input  logic [NLANE-1:0]         lap_tick_i,
  input  logic [NLANE*PW-1:0]      phase_i,
  input  logic [NLANE-1:0]         fine_done_i,
  input  logic [NLANE*(FINEW+1)-1:0] fine_cnt_i,
  input  logic [NLANE-1:0]         out_ready_i,
  output logic [NLANE-1:0]         out_valid_o,
  output logic [NLANE*CODEW-1:0]   out_code_o,
  output logic [NLANE-1:0]         out_err_o,
  output logic [NLANE-1:0]         out_oor_o,
  output logic [NLANE*DROPW-1:0]   drop_cnt_o
);
  generate
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      tdc_lane #(
        .STAGES(STAGES), .LAPW(LAPW), .FINEW(FINEW),
        .FINE_TMO(FINE_TMO), .DROPW(DROPW)
      ) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i[l]),
        .stop      (stop_i[l]),
        .lap_tick  (lap_tick_i[l]),
        .phase     (phase_i[l*PW +: PW]),
        .fine_done (fine_done_i[l]),
        .fine_cnt  (fine_cnt_i[l*(FINEW+1) +: FINEW+1]),
        .out_ready (out_ready_i[l]),
        .out_valid (out_valid_o[l]),
        .out_code  (out_code_o[l*CODEW +: CODEW]),
        .out_err   (out_err_o[l]),
        .out_oor   (out_oor_o[l]),
        .drop_cnt  (drop_cnt_o[l*DROPW +: DROPW])
      );
    end
  endgenerate
endmodule

// File: rtl/tdc_readout_checker.sv
module tdc_readout_checker #(
  parameter int NLANE = 2,
  parameter int CODEW = 8,
  parameter int DROPW = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NLANE-1:0]       start_i,
  input logic [NLANE-1:0]       out_ready_i,
  input logic [NLANE-1:0]       out_valid_o,
  input logic [NLANE*CODEW-1:0] out_code_o,
  input logic [NLANE-1:0]       out_err_o,
  input logic [NLANE-1:0]       out_oor_o,
  input logic [NLANE*DROPW-1:0] drop_cnt_o
);
  generate
    for (genvar l = 0; l < NLANE; l++) begin : g_chk
      assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o[l] && !out_ready_i[l] |=>
          out_valid_o[l] && $stable(out_code_o[l*CODEW +: CODEW]) &&
          $stable(out_err_o[l]) && $stable(out_oor_o[l]));

      assert_oor_code_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_oor_o[l] |-> out_code_o[l*CODEW +: CODEW] == '0 && !out_err_o[l]);

      assert_drop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i[l] && out_valid_o[l] |=>
          (drop_cnt_o[l*DROPW +: DROPW] == $past(drop_cnt_o[l*DROPW +: DROPW]) + 1'b1) ||
          ($past(drop_cnt_o[l*DROPW +: DROPW]) == '1));

      assert_drop_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drop_cnt_o[l*DROPW +: DROPW] >= $past(drop_cnt_o[l*DROPW +: DROPW]));
    end
  endgenerate
endmodule

bind tdc_vernier_readout tdc_readout_checker #(
  .NLANE(NLANE), .CODEW(CODEW), .DROPW(DROPW)
) u_checker (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .out_ready_i(out_ready_i),
  .out_valid_o(out_valid_o), .out_code_o(out_code_o), .out_err_o(out_err_o),
  .out_oor_o(out_oor_o), .drop_cnt_o(drop_cnt_o)
);

// File: tb/tb_tdc_vernier_readout.sv
module tb_tdc_vernier_readout;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  start_i = '0, stop_i = '0, lap_tick_i = '0, fine_done_i = '0;
  logic [5:0]  phase_i = '0;
  logic [7:0]  fine_cnt_i = '0;
  logic [1:0]  out_ready_i = 2'b11;
  logic [1:0]  out_valid_o, out_err_o, out_oor_o;
  logic [15:0] out_code_o, drop_cnt_o;

  int total = 0, bad = 0;
  int exp_drop [2] = '{0, 0};
  bit done = 0;

  always #5 clk = ~clk;

  tdc_vernier_readout #(.FINE_TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .lap_tick_i(lap_tick_i), .phase_i(phase_i), .fine_done_i(fine_done_i),
    .fine_cnt_i(fine_cnt_i), .out_ready_i(out_ready_i), .out_valid_o(out_valid_o),
    .out_code_o(out_code_o), .out_err_o(out_err_o), .out_oor_o(out_oor_o),
    .drop_cnt_o(drop_cnt_o)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int stage_of(int ph);
    int n = 0;
    while (n < 3 && ph[n]) n++;
    return n;
  endfunction

  function automatic int code_of(int laps, int ph, int fn);
    int c = (laps * 4 + stage_of(ph)) * 8;
    if (fn < 8) c += fn;
    return c;
  endfunction

  task automatic pulse_start(int ln);
    @(negedge clk) start_i[ln] = 1'b1;
    @(negedge clk) start_i[ln] = 1'b0;
  endtask

  // dodone=0 exercises the timeout; dodrop pulses START while running
  task automatic meas(int ln, int laps, int ph, int fn, bit dodone, bit dodrop, string tag);
    int oth = 1 - ln;
    logic [7:0] oth_code = out_code_o[oth*8 +: 8];
    int exp_code = code_of(laps, ph, fn);
    bit exp_err = (fn >= 8) || !dodone;
    pulse_start(ln);
    for (int i = 0; i < laps; i++) begin
      @(negedge clk) lap_tick_i[ln] = 1'b1;
      @(negedge clk) lap_tick_i[ln] = 1'b0;
    end
    if (dodrop) begin
      pulse_start(ln);
      exp_drop[ln]++;
    end
    phase_i[ln*3 +: 3] = 3'(ph);
    @(negedge clk) stop_i[ln] = 1'b1;
    @(negedge clk) stop_i[ln] = 1'b0;
    @(negedge clk);
    if (dodone) begin
      fine_cnt_i[ln*4 +: 4] = 4'(fn);
      fine_done_i[ln] = 1'b1;
      @(negedge clk) fine_done_i[ln] = 1'b0;
    end else begin
      repeat (TMO - 1) @(negedge clk);
      check(out_valid_o[ln] == 1'b0, {tag, " R5 early"}, out_valid_o[ln], 0);
      @(negedge clk);
    end
    check(out_valid_o[ln] == 1'b1, {tag, " valid R2"}, out_valid_o[ln], 1);
    check(out_code_o[ln*8 +: 8] == 8'(exp_code), {tag, " code"}, out_code_o[ln*8 +: 8], exp_code);
    check(out_err_o[ln] == exp_err, {tag, " err R4"}, out_err_o[ln], exp_err);
    check(drop_cnt_o[ln*8 +: 8] == 8'(exp_drop[ln]), {tag, " drop R9"},
          drop_cnt_o[ln*8 +: 8], exp_drop[ln]);
    check(out_valid_o[oth] == 1'b0 && out_code_o[oth*8 +: 8] == oth_code,
          {tag, " other lane R10"}, out_code_o[oth*8 +: 8], oth_code);
    if (out_ready_i[ln]) begin
      @(negedge clk);
      check(out_valid_o[ln] == 1'b0, {tag, " consumed R7"}, out_valid_o[ln], 0);
    end
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    check(out_valid_o == 2'b00, "R1 valid", out_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid_o == 2'b00, "R1 valid after", out_valid_o, 0);
    check(drop_cnt_o == '0, "R1 drop", drop_cnt_o, 0);

    meas(0, 3, 3'b011, 5, 1, 0, "R2 basic");
    meas(0, 1, 3'b101, 0, 1, 0, "R3 bubble");
    meas(0, 7, 3'b111, 7, 1, 0, "R3 top");
    meas(0, 2, 3'b001, 9, 1, 0, "R4 fine8+");
    meas(1, 4, 3'b000, 15, 1, 0, "R4 fine15");
    meas(0, 5, 3'b011, 0, 0, 0, "R5 timeout");
    meas(1, 2, 3'b011, 3, 1, 1, "R9 drop");

    // R6: overflow on the eighth lap tick
    pulse_start(0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) lap_tick_i[0] = 1'b1;
      @(negedge clk) lap_tick_i[0] = 1'b0;
      if (i == 6) check(out_valid_o[0] == 1'b0, "R6 before", out_valid_o[0], 0);
    end
    check(out_valid_o[0] && out_oor_o[0], "R6 oor", out_oor_o[0], 1);
    check(out_code_o[7:0] == 8'd0, "R6 code", out_code_o[7:0], 0);
    @(negedge clk);
    check(out_valid_o[0] == 1'b0, "R6 idle", out_valid_o[0], 0);

    // R7: back-pressure holds the result
    out_ready_i[0] = 1'b0;
    meas(0, 6, 3'b001, 2, 1, 0, "R7 stall");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid_o[0] && out_code_o[7:0] == 8'(code_of(6, 1, 2)),
            "R7 hold", out_code_o[7:0], code_of(6, 1, 2));
    end
    pulse_start(0);
    exp_drop[0]++;
    check(drop_cnt_o[7:0] == 8'(exp_drop[0]), "R9 drop in output", drop_cnt_o[7:0], exp_drop[0]);
    out_ready_i[0] = 1'b1;
    @(negedge clk);
    check(out_valid_o[0] == 1'b0, "R7 release", out_valid_o[0], 0);

    // R8: stop in idle has no effect
    @(negedge clk) stop_i[1] = 1'b1;
    @(negedge clk) stop_i[1] = 1'b0;
    repeat (4) @(negedge clk);
    check(out_valid_o[1] == 1'b0, "R8 no result", out_valid_o[1], 0);
    meas(1, 3, 3'b111, 6, 1, 0, "R8 next ok");

    for (int n = 0; n < 40; n++) begin
      int ln = $urandom % 2;
      int fn = ($urandom % 5 == 0) ? 8 + $urandom % 8 : $urandom % 8;
      meas(ln, $urandom % 8, $urandom % 8, fn, 1, ($urandom % 6 == 0), "R2 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule